// File: doc/BRIEF.md
# Trace Session Controller

This block runs the life cycle of one processor trace capture. Software start and stop strobes open and close a session. While a session runs, the block watches the hart's halt and have-reset indications and the state of the downstream trace FIFO. It publishes a two-bit work state, and packet formation logic downstream reads that state. The block also asks that logic for three kinds of marker packet: a last-address packet when the hart halts or resets, a restart packet when the hart resumes, and a synchronisation packet.

A synchronisation packet is requested in two cases. The first is periodic: the block counts either clock cycles or written packets against a programmable threshold. The second follows recovery: when a FIFO overflow has discarded trace data and auto-restart is on, a sync packet is requested as soon as the FIFO has drained. Two policies cover a FIFO that is close to full. With stalling on, the block asks the processor to stall. With stalling off, an overflow drops the session into a lost state. An overflow also sets a sticky interrupt flag, which has its own enable and clear.

Top module: `trc_session_ctl`

## Requirements
- R1: After reset, work_state_o is 0 (idle), fifo_empty_o is 1, and stall_req_o, last_addr_req_o, restart_req_o, sync_req_o, ovf_raw_o and ovf_irq_o are all 0.
- R2: The work state encoding is 0 idle, 1 working, 2 waiting, 3 lost. A start_i seen in idle moves the state to 1 at the next edge. start_i has no effect in any other state.
- R3: stop_i returns the state to 0 at the next edge from every state. When start_i and stop_i are seen together in idle, the state stays 0.
- R4: In working state, the state moves to 2 at the next edge when hart_halted_i is high with halt_track_en_i high, or when hart_reset_i is high with reset_track_en_i high. last_addr_req_o is high for exactly the one cycle in which state 2 first appears. With both tracking enables low, the hart indications leave the state at 1 and produce no pulse.
- R5: In state 2, once no enabled hart condition remains, the state returns to 1 and restart_req_o is high for exactly that first cycle.
- R6: In working state, fifo_ovf_i with stall_en_i low moves the state to 3. This takes precedence over entry to state 2 in the same cycle, so no last-address pulse follows. With stall_en_i high, an overflow leaves the state at 1.
- R7: In state 3 with restart_en_i high, the state returns to 1 at the first edge at which fifo_level_i is 0, and sync_req_o pulses in the same cycle as the return. With restart_en_i low, the state stays 3 until stop_i.
- R8: stall_req_o is the registered value of stall_en_i AND fifo_afull_i AND (state is 1), so it appears one edge after the condition.
- R9: Periodic sync is active only in state 1. sync_mode_i 2 counts cycles and mode 3 counts pkt_done_i strobes. sync_req_o pulses when sync_period_i counts have been reached, and the counter then clears. Modes 0 and 1 never produce a periodic pulse.
- R10: ovf_raw_o is set by fifo_ovf_i in any state and held until ovf_irq_clr_i. If the set and the clear arrive in the same cycle, the set wins. ovf_irq_o equals ovf_raw_o AND ovf_irq_en_i.
- R11: fifo_empty_o is the registered result of fifo_level_i equal to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Session start strobe |
| stop_i | input | 1 | Session stop strobe |
| hart_halted_i | input | 1 | Hart is halted |
| hart_reset_i | input | 1 | Hart has been reset |
| halt_track_en_i | input | 1 | Report halts |
| reset_track_en_i | input | 1 | Report hart resets |
| stall_en_i | input | 1 | Stall the hart instead of losing trace |
| restart_en_i | input | 1 | Leave the lost state automatically |
| fifo_level_i | input | LVL_W | FIFO occupancy |
| fifo_afull_i | input | 1 | FIFO almost full |
| fifo_ovf_i | input | 1 | A write hit a full FIFO |
| pkt_done_i | input | 1 | One packet was written |
| sync_mode_i | input | 2 | 0/1 off, 2 cycles, 3 packets |
| sync_period_i | input | CNT_W | Resync threshold |
| ovf_irq_en_i | input | 1 | Overflow interrupt enable |
| ovf_irq_clr_i | input | 1 | Overflow interrupt clear strobe |
| work_state_o | output | 2 | Work state |
| fifo_empty_o | output | 1 | FIFO empty flag |
| stall_req_o | output | 1 | Processor stall request |
| last_addr_req_o | output | 1 | Last-address packet request |
| restart_req_o | output | 1 | Restart packet request |
| sync_req_o | output | 1 | Sync packet request |
| ovf_raw_o | output | 1 | Sticky overflow flag |
| ovf_irq_o | output | 1 | Overflow interrupt |

## Verification
Three coincidences are driven on purpose. The first is an overflow in the same cycle as a hart halt while tracking is on. The next sample must show state 3 with no last-address pulse, and the overflow flag must be set. The second is start and stop together in idle, which must leave the state at 0. The third is an overflow in the same cycle as an interrupt clear, and the flag must survive it.

// File: rtl/trc_pkg.sv
package trc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2,
        ST_LOST = 2'd3
    } trc_state_e;

    localparam logic [1:0] SYNC_BY_CYCLE  = 2'd2;
    localparam logic [1:0] SYNC_BY_PACKET = 2'd3;
endpackage

// File: rtl/trc_fsm.sv
module trc_fsm
    import trc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       halt_i,
    input  logic       hrst_i,
    input  logic       halt_en_i,
    input  logic       hrst_en_i,
    input  logic       stall_en_i,
    input  logic       restart_en_i,
    input  logic       ovf_i,
    input  logic       drained_i,
    output trc_state_e state_o,
    output logic       last_addr_o,
    output logic       restart_o,
    output logic       recover_o
);
    typedef struct packed {
        trc_state_e st;
        logic       la;
        logic       rs;
    } fsm_t;

    fsm_t s_d, s_q;
    logic hold_cond;
    logic recover;

    always_comb begin
        s_d       = s_q;
        s_d.la    = 1'b0;
        s_d.rs    = 1'b0;
        hold_cond = (halt_i & halt_en_i) | (hrst_i & hrst_en_i);
        recover   = (s_q.st == ST_LOST) & restart_en_i & drained_i & ~stop_i;
        unique case (s_q.st)
            ST_IDLE: if (start_i && !stop_i) s_d.st = ST_RUN;
            ST_RUN: begin
                if (stop_i)                       s_d.st = ST_IDLE;
                else if (ovf_i && !stall_en_i)    s_d.st = ST_LOST;
                else if (hold_cond) begin
                    s_d.st = ST_HOLD;
                    s_d.la = 1'b1;
                end
            end
            ST_HOLD: begin
                if (stop_i)          s_d.st = ST_IDLE;
                else if (!hold_cond) begin
                    s_d.st = ST_RUN;
                    s_d.rs = 1'b1;
                end
            end
            ST_LOST: begin
                if (stop_i)       s_d.st = ST_IDLE;
                else if (recover) s_d.st = ST_RUN;
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, la: 1'b0, rs: 1'b0};
        else        s_q <= s_d;
    end

    assign state_o     = s_q.st;
    assign last_addr_o = s_q.la;
    assign restart_o   = s_q.rs;
    assign recover_o   = recover;

    a_r3_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_i |=> (state_o == ST_IDLE));
    a_r2_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_IDLE && start_i && !stop_i) |=> (state_o == ST_RUN));
    a_r4_la_in_hold: assert property (@(posedge clk) disable iff (!rst_n)
        last_addr_o |-> (state_o == ST_HOLD && $past(state_o) == ST_RUN));
    a_r5_rs_after_hold: assert property (@(posedge clk) disable iff (!rst_n)
        restart_o |-> (state_o == ST_RUN && $past(state_o) == ST_HOLD));
    a_r7_lost_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == ST_LOST && !stop_i && !restart_en_i) |=> (state_o == ST_LOST));
endmodule

// File: rtl/trc_resync.sv
module trc_resync
    import trc_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active_i,
    input  logic [1:0]       mode_i,
    input  logic             pkt_i,
    input  logic [CNT_W-1:0] period_i,
    input  logic             force_i,
    output logic             sync_o
);
    localparam int EXT_W = CNT_W + 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             sync;
    } rs_t;

    rs_t r_d, r_q;
    logic             tick;
    logic [EXT_W-1:0] next_cnt;

    always_comb begin
        r_d      = r_q;
        r_d.sync = 1'b0;
        tick     = active_i & ((mode_i == SYNC_BY_CYCLE) | ((mode_i == SYNC_BY_PACKET) & pkt_i));
        next_cnt = {1'b0, r_q.cnt} + EXT_W'(1);
        if (!active_i || mode_i < SYNC_BY_CYCLE) r_d.cnt = '0;
        if (tick) begin
            if (next_cnt >= {1'b0, period_i}) begin
                r_d.sync = 1'b1;
                r_d.cnt  = '0;
            end else begin
                r_d.cnt = next_cnt[CNT_W-1:0];
            end
        end
        if (force_i) begin
            r_d.sync = 1'b1;
            r_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign sync_o = r_q.sync;

    a_r9_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i < SYNC_BY_CYCLE && !force_i) |=> !sync_o);
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!active_i && !force_i) |=> !sync_o);
endmodule

// File: rtl/trc_ovf_irq.sv
module trc_ovf_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic clr_i,
    input  logic en_i,
    output logic raw_o,
    output logic irq_o
);
    logic raw_d, raw_q;

    always_comb raw_d = (raw_q & ~clr_i) | ovf_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= 1'b0;
        else        raw_q <= raw_d;
    end

    assign raw_o = raw_q;
    assign irq_o = raw_q & en_i;

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_i |=> raw_o);
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_o && !clr_i) |=> raw_o);
endmodule

// File: rtl/trc_session_ctl.sv
module trc_session_ctl
    import trc_pkg::*;
#(
    parameter int LVL_W = 5,
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             hart_halted_i,
    input  logic             hart_reset_i,
    input  logic             halt_track_en_i,
    input  logic             reset_track_en_i,
    input  logic             stall_en_i,
    input  logic             restart_en_i,
    input  logic [LVL_W-1:0] fifo_level_i,
    input  logic             fifo_afull_i,
    input  logic             fifo_ovf_i,
    input  logic             pkt_done_i,
    input  logic [1:0]       sync_mode_i,
    input  logic [CNT_W-1:0] sync_period_i,
    input  logic             ovf_irq_en_i,
    input  logic             ovf_irq_clr_i,
    output logic [1:0]       work_state_o,
    output logic             fifo_empty_o,
    output logic             stall_req_o,
    output logic             last_addr_req_o,
    output logic             restart_req_o,
    output logic             sync_req_o,
    output logic             ovf_raw_o,
    output logic             ovf_irq_o
);
    typedef struct packed {
        logic empty;
        logic stall;
    } top_t;

    top_t       t_d, t_q;
    trc_state_e state;
    logic       drained;
    logic       recover;

    assign drained = (fifo_level_i == '0);

    trc_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .halt_i       (hart_halted_i),
        .hrst_i       (hart_reset_i),
        .halt_en_i    (halt_track_en_i),
        .hrst_en_i    (reset_track_en_i),
        .stall_en_i   (stall_en_i),
        .restart_en_i (restart_en_i),
        .ovf_i        (fifo_ovf_i),
        .drained_i    (drained),
        .state_o      (state),
        .last_addr_o  (last_addr_req_o),
        .restart_o    (restart_req_o),
        .recover_o    (recover)
    );

    trc_resync #(.CNT_W(CNT_W)) u_resync (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (state == ST_RUN),
        .mode_i   (sync_mode_i),
        .pkt_i    (pkt_done_i),
        .period_i (sync_period_i),
        .force_i  (recover),
        .sync_o   (sync_req_o)
    );

    trc_ovf_irq u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .ovf_i (fifo_ovf_i),
        .clr_i (ovf_irq_clr_i),
        .en_i  (ovf_irq_en_i),
        .raw_o (ovf_raw_o),
        .irq_o (ovf_irq_o)
    );

    always_comb begin
        t_d.empty = drained;
        t_d.stall = stall_en_i & fifo_afull_i & (state == ST_RUN);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '{empty: 1'b1, stall: 1'b0};
        else        t_q <= t_d;
    end

    assign work_state_o = state;
    assign fifo_empty_o = t_q.empty;
    assign stall_req_o  = t_q.stall;

    a_r8_stall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req_o |-> ($past(stall_en_i) && $past(fifo_afull_i)));
    a_r11_empty_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_level_i != '0) |=> !fifo_empty_o);
    a_r6_lost_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && fifo_ovf_i && !stall_en_i && !stop_i) |=> (work_state_o == 2'd3 && !last_addr_req_o));
endmodule

// File: tb/sim_trc_session_ctl.sv
module sim_trc_session_ctl;
    localparam int LVL_W = 5;
    localparam int CNT_W = 24;
    localparam int NROWS = 16;

    // row: [10]start [9]stop [8]halt [7]hrst [6]ovf [5]level0 [4:3]state [2]la [1]rs [0]sync
    localparam logic [10:0] ROWS [NROWS] = '{
        11'b10000101000, 11'b00000101000, 11'b00100110100, 11'b00100110000,
        11'b00000101010, 11'b00010110100, 11'b00000101010, 11'b00001011000,
        11'b00000011000, 11'b00000101001, 11'b10000101000, 11'b01000100000,
        11'b11000100000, 11'b10000101000, 11'b00101011000, 11'b01000100000
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 0, stop_i = 0, hart_halted_i = 0, hart_reset_i = 0;
    logic halt_track_en_i = 0, reset_track_en_i = 0, stall_en_i = 0, restart_en_i = 0;
    logic [LVL_W-1:0] fifo_level_i = '0;
    logic fifo_afull_i = 0, fifo_ovf_i = 0, pkt_done_i = 0;
    logic [1:0] sync_mode_i = 2'd0;
    logic [CNT_W-1:0] sync_period_i = 24'd128;
    logic ovf_irq_en_i = 0, ovf_irq_clr_i = 0;
    logic [1:0] work_state_o;
    logic fifo_empty_o, stall_req_o, last_addr_req_o, restart_req_o, sync_req_o, ovf_raw_o, ovf_irq_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;

    trc_session_ctl #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .hart_halted_i(hart_halted_i), .hart_reset_i(hart_reset_i),
        .halt_track_en_i(halt_track_en_i), .reset_track_en_i(reset_track_en_i),
        .stall_en_i(stall_en_i), .restart_en_i(restart_en_i),
        .fifo_level_i(fifo_level_i), .fifo_afull_i(fifo_afull_i), .fifo_ovf_i(fifo_ovf_i),
        .pkt_done_i(pkt_done_i), .sync_mode_i(sync_mode_i), .sync_period_i(sync_period_i),
        .ovf_irq_en_i(ovf_irq_en_i), .ovf_irq_clr_i(ovf_irq_clr_i),
        .work_state_o(work_state_o), .fifo_empty_o(fifo_empty_o), .stall_req_o(stall_req_o),
        .last_addr_req_o(last_addr_req_o), .restart_req_o(restart_req_o),
        .sync_req_o(sync_req_o), .ovf_raw_o(ovf_raw_o), .ovf_irq_o(ovf_irq_o)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic clear_strobes();
        start_i = 0; stop_i = 0; hart_halted_i = 0; hart_reset_i = 0;
        fifo_ovf_i = 0; pkt_done_i = 0; ovf_irq_clr_i = 0;
    endtask

    task automatic go_idle();
        clear_strobes();
        stop_i = 1;
        cyc();
        stop_i = 0;
    endtask

    initial begin
        #(4 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        cyc();
        // R1 reset values
        check("R1 state", work_state_o, 0);
        check("R1 empty", fifo_empty_o, 1);
        check("R1 stall", stall_req_o, 0);
        check("R1 pulses", {last_addr_req_o, restart_req_o, sync_req_o}, 0);
        check("R1 irq", {ovf_raw_o, ovf_irq_o}, 0);

        // table walk: R2 R3 R4 R5 R6 R7
        halt_track_en_i = 1; reset_track_en_i = 1; restart_en_i = 1;
        for (int i = 0; i < NROWS; i++) begin
            start_i       = ROWS[i][10];
            stop_i        = ROWS[i][9];
            hart_halted_i = ROWS[i][8];
            hart_reset_i  = ROWS[i][7];
            fifo_ovf_i    = ROWS[i][6];
            fifo_level_i  = ROWS[i][5] ? 5'd0 : 5'd3;
            cyc();
            check($sformatf("R2/R3/R6 row%0d state", i), work_state_o, int'(ROWS[i][4:3]));
            check($sformatf("R4 row%0d last_addr", i), last_addr_req_o, ROWS[i][2]);
            check($sformatf("R5 row%0d restart", i), restart_req_o, ROWS[i][1]);
            check($sformatf("R7 row%0d sync", i), sync_req_o, ROWS[i][0]);
        end
        clear_strobes();
        fifo_level_i = 0;
        check("R10 raw after table overflows", ovf_raw_o, 1);

        // R4 tracking disabled
        halt_track_en_i = 0; reset_track_en_i = 0;
        start_i = 1; cyc(); start_i = 0;
        hart_halted_i = 1; hart_reset_i = 1; cyc();
        check("R4 disabled state", work_state_o, 1);
        check("R4 disabled no pulse", last_addr_req_o, 0);
        go_idle();

        // R6 / R8 stall path
        stall_en_i = 1; fifo_afull_i = 1;
        start_i = 1; cyc(); start_i = 0;
        check("R8 stall not before run", stall_req_o, 0);
        cyc();
        check("R8 stall high", stall_req_o, 1);
        fifo_ovf_i = 1; cyc(); fifo_ovf_i = 0;
        check("R6 stall keeps working", work_state_o, 1);
        fifo_afull_i = 0; cyc();
        check("R8 stall drops", stall_req_o, 0);
        stall_en_i = 0;
        go_idle();

        // R7 no auto-restart
        restart_en_i = 0;
        start_i = 1; cyc(); start_i = 0;
        fifo_ovf_i = 1; cyc(); fifo_ovf_i = 0;
        check("R7 lost entry", work_state_o, 3);
        repeat (4) cyc();
        check("R7 stays lost", work_state_o, 3);
        check("R7 no sync", sync_req_o, 0);
        go_idle();
        check("R3 stop from lost", work_state_o, 0);

        // R9 cycle mode, period 4
        sync_mode_i = 2'd2; sync_period_i = 24'd4;
        start_i = 1; cyc(); start_i = 0;
        for (int k = 1; k <= 8; k++) begin
            cyc();
            check($sformatf("R9 cycle mode k=%0d", k), sync_req_o, (k % 4 == 0) ? 1 : 0);
        end
        go_idle();

        // R9 packet mode, period 3
        sync_mode_i = 2'd3; sync_period_i = 24'd3;
        start_i = 1; cyc(); start_i = 0;
        cyc();
        check("R9 no packets no sync", sync_req_o, 0);
        pkt_done_i = 1;
        cyc(); cyc();
        check("R9 two packets", sync_req_o, 0);
        cyc();
        check("R9 third packet", sync_req_o, 1);
        pkt_done_i = 0; cyc();
        check("R9 pulse ends", sync_req_o, 0);
        go_idle();

        // R9 mode 1 is off
        sync_mode_i = 2'd1; sync_period_i = 24'd1;
        start_i = 1; cyc(); start_i = 0;
        pkt_done_i = 1;
        begin
            int seen = 0;
            for (int k = 0; k < 10; k++) begin
                cyc();
                seen += sync_req_o;
            end
            check("R9 mode1 silent", seen, 0);
        end
        pkt_done_i = 0;
        sync_mode_i = 2'd0;
        go_idle();

        // R10 interrupt
        ovf_irq_clr_i = 1; cyc(); ovf_irq_clr_i = 0;
        check("R10 clear", ovf_raw_o, 0);
        fifo_ovf_i = 1; cyc(); fifo_ovf_i = 0;
        check("R10 set in idle", ovf_raw_o, 1);
        check("R10 masked", ovf_irq_o, 0);
        check("R10 idle overflow ignored by state", work_state_o, 0);
        ovf_irq_en_i = 1; #1;
        check("R10 enabled", ovf_irq_o, 1);
        fifo_ovf_i = 1; ovf_irq_clr_i = 1; cyc();
        fifo_ovf_i = 0; ovf_irq_clr_i = 0;
        check("R10 set beats clear", ovf_raw_o, 1);
        ovf_irq_clr_i = 1; cyc(); ovf_irq_clr_i = 0;
        check("R10 cleared irq", ovf_irq_o, 0);

        // R11 empty flag
        fifo_level_i = 5'd7; cyc();
        check("R11 not empty", fifo_empty_o, 0);
        fifo_level_i = 5'd0; cyc();
        check("R11 empty again", fifo_empty_o, 1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule